// File: doc/BRIEF.md
# Timed Output Pattern Generator

This block drives a 5-bit output port from patterns that software schedules in advance. It has three identical channels. Software places a pattern in a channel's data register and then writes a 16-bit activation time. Completing the time write puts the pattern and the time into that channel's queue as a single entry. A shared free-running counter runs while an enable input is high. When the time of a channel's oldest entry equals the counter, the channel switches to that entry's pattern and drops the entry from its queue.

The three channel outputs are combined with a bitwise OR into one port. This lets several channels own different bits of the port, or lets them overlay one another. Each channel has a byte-wide register window with a control/status register, a data register and a time value split into two byte registers. The windows sit at a stride of four bytes on a simple synchronous register port: writes are strobed and reads are combinational.

Top module: `tpg_top`

## Requirements
- R1: After reset every queue is empty, every channel output is 0 and `pat_o` is 0. Each status register reads 0x01 and each data register reads 0x00.
- R2: A write to the time-high register only latches the byte, and the queue stays empty. A write to the time-low register pushes one entry made of the pending pattern, the latched high byte and the written low byte.
- R3: Each queue holds 4 entries. Status bit 1 is set while it holds 4. A push to a full queue is dropped, and a later drain shows only the first 4 entries.
- R4: When the time of the oldest entry equals the counter, that entry's pattern appears at the channel output on the next cycle. The entry is removed at the same time.
- R5: The shared counter advances by one on each cycle that `tick_en_i` is high and holds its value otherwise. A stalled counter never reaches a later scheduled time.
- R6: Writing 1 to status bit 2 empties that channel's queue. Writing 0 there has no effect, and the bit always reads 0. Entries that were cleared never reach the output.
- R7: A read of the data register returns the pattern the channel drives now, in bits 4..0, with bits 7..5 as 0. The written but unissued pattern is not returned. Written bits 7..5 are ignored.
- R8: `pat_o` is the bitwise OR of the three channel outputs.
- R9: Channel c occupies addresses 4c to 4c+3. Offset 0 is status/control (bit 0 empty, bit 1 full, bit 2 clear), offset 1 is data, offset 2 is time-high and offset 3 is time-low.
- R10: Entries issue strictly in push order. A later entry whose time has come does not issue while an older entry is still waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | Advances the shared time counter |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pat_o | output | 5 | OR of the channel outputs |

## Verification
The bench builds the block with its default parameters: three channels, 5-bit patterns, 16-bit times and four entries per queue. A depth of four makes the full flag and the dropped fifth push reachable in a few writes. Three channels allow events on separate channels in the same cycle, which exercises the OR merge. The bench holds the counter with the enable input while it schedules. This fixes the times exactly and lets it show stalling, clearing and in-order blocking within a few hundred cycles.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    REG_CSR  = 2'd0,
    REG_DATA = 2'd1,
    REG_THI  = 2'd2,
    REG_TLO  = 2'd3
  } reg_sel_e;

  localparam int CSR_EMPTY_BIT = 0;
  localparam int CSR_FULL_BIT  = 1;
  localparam int CSR_CLR_BIT   = 2;
  localparam int BUS_W         = 8;
endpackage

// File: rtl/tpg_timebase.sv
module tpg_timebase #(
  parameter int TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [TIME_W-1:0] now_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   now_o <= '0;
    else if (en_i) now_o <= now_o + 1'b1;
  end
endmodule

// File: rtl/tpg_fifo.sv
module tpg_fifo #(
  parameter int W     = 21,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  // full is judged before any same-cycle pop
  assign push_ok = push_i && !full_o && !clr_i;
  assign pop_ok  = pop_i && !empty_o && !clr_i;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= din_i;
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> full_o);
  p_clear_empties_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/tpg_chan.sv
module tpg_chan
  import tpg_pkg::*;
#(
  parameter int PAT_W  = 5,
  parameter int TIME_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] now_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  reg_sel_e          off_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [PAT_W-1:0]  out_o
);
  localparam int HI_W = TIME_W - BUS_W;
  localparam int EW   = PAT_W + TIME_W;

  logic [PAT_W-1:0] data_q;
  logic [HI_W-1:0]  thi_q;
  logic             wr, clr, push, match;
  logic             f_empty, f_full;
  logic [EW-1:0]    head;

  assign wr    = sel_i && we_i;
  assign clr   = wr && (off_i == REG_CSR) && wdata_i[CSR_CLR_BIT];
  assign push  = wr && (off_i == REG_TLO);
  assign match = !f_empty && (head[TIME_W-1:0] == now_i);

  tpg_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .push_i  (push),
    .din_i   ({data_q, thi_q, wdata_i}),
    .pop_i   (match),
    .head_o  (head),
    .empty_o (f_empty),
    .full_o  (f_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      thi_q  <= '0;
      out_o  <= '0;
    end else begin
      if (wr && off_i == REG_DATA) data_q <= wdata_i[PAT_W-1:0];
      if (wr && off_i == REG_THI)  thi_q  <= wdata_i[HI_W-1:0];
      if (match)                   out_o  <= head[EW-1:TIME_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (off_i)
      REG_CSR: begin
        rdata_o[CSR_EMPTY_BIT] = f_empty;
        rdata_o[CSR_FULL_BIT]  = f_full;
      end
      REG_DATA: rdata_o[PAT_W-1:0] = out_o;
      default:  rdata_o = '0;
    endcase
  end

  p_clear_keeps_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !match) |=> $stable(out_o));
endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int PAT_W  = 5,
  parameter int TIME_W = 16,
  parameter int DEPTH  = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [PAT_W-1:0]  pat_o
);
  logic [TIME_W-1:0] now;
  logic [CH_W-1:0]   ch_idx;
  reg_sel_e          off;
  logic [NUM_CH-1:0] sel;
  logic [BUS_W-1:0]  ch_rdata [NUM_CH];
  logic [PAT_W-1:0]  ch_out   [NUM_CH];

  assign ch_idx = addr_i[ADDR_W-1:2];
  assign off    = reg_sel_e'(addr_i[1:0]);

  tpg_timebase #(.TIME_W(TIME_W)) u_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en_i),
    .now_o  (now)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign sel[c] = (ch_idx == CH_W'(c));
    tpg_chan #(.PAT_W(PAT_W), .TIME_W(TIME_W), .DEPTH(DEPTH)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .now_i   (now),
      .sel_i   (sel[c]),
      .we_i    (we_i),
      .off_i   (off),
      .wdata_i (wdata_i),
      .rdata_o (ch_rdata[c]),
      .out_o   (ch_out[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    pat_o   = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel[c]) rdata_o = ch_rdata[c];
      pat_o = pat_o | ch_out[c];
    end
  end

  p_cnt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i |=> $stable(now));
  p_cnt_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_i |=> (now == $past(now) + 1'b1));
endmodule

// File: tb/tpg_top_bench.sv
`timescale 1ns/1ps
module tpg_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] pat;

  int checks = 0;
  int fails  = 0;
  bit timeout = 1'b0;

  always #2.5 clk = ~clk;

  tpg_top u_tpg_top (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pat_o(pat)
  );

  // scoreboard model: per-channel expected queues, filled by the driver's writes
  logic [20:0] mq [3][4];
  int          mn [3];
  logic [4:0]  mdata [3];
  logic [7:0]  mhi [3];
  logic [4:0]  mout [3];
  logic [15:0] mcnt;
  bit          fired;

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt = '0; fired = 1'b0;
      for (int c = 0; c < 3; c++) begin mn[c] = 0; mdata[c] = '0; mhi[c] = '0; mout[c] = '0; end
    end else begin
      int pre [3];
      fired = 1'b0;
      for (int c = 0; c < 3; c++) begin
        pre[c] = mn[c];
        if (mn[c] > 0 && mq[c][0][15:0] == mcnt) begin
          mout[c] = mq[c][0][20:16];
          for (int i = 0; i < 3; i++) mq[c][i] = mq[c][i+1];
          mn[c] = mn[c] - 1;
          fired = 1'b1;
        end
      end
      if (we && addr[3:2] != 2'd3) begin
        int ch;
        ch = int'(addr[3:2]);
        case (addr[1:0])
          2'd0: if (wdata[2]) mn[ch] = 0;
          2'd1: mdata[ch] = wdata[4:0];
          2'd2: mhi[ch] = wdata;
          default: if (pre[ch] < 4) begin
            mq[ch][mn[ch]] = {mdata[ch], mhi[ch], wdata};
            mn[ch] = mn[ch] + 1;
          end
        endcase
      end
      if (tick_en) mcnt = mcnt + 1'b1;
    end
  end

  // monitor: compare the merged port against the scoreboard every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] exp_o;
      exp_o = mout[0] | mout[1] | mout[2];
      if (fired || pat !== exp_o) checks++;
      if (pat !== exp_o) begin
        fails++;
        $display("FAIL R4/R8 pat_o actual=%h expected=%h", pat, exp_o);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp_v, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp_v);
  endtask

  task automatic sched(input int ch, input logic [7:0] p, input int delta);
    logic [15:0] t;
    t = mcnt + 16'(delta);
    wr(4'(ch*4+1), p);
    wr(4'(ch*4+2), t[15:8]);
    wr(4'(ch*4+3), t[7:0]);
  endtask

  task automatic run(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic body();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R9 reset state
    for (int c = 0; c < 3; c++) begin
      rd(4'(c*4), 8'h01, "R1 status after reset");
      rd(4'(c*4+1), 8'h00, "R1 data after reset");
    end
    chk("R1 pat_o after reset", {3'b0, pat}, 8'h00);

    // R2: high byte only latches; low byte pushes
    wr(4'h1, 8'hF3);
    wr(4'h2, 8'h00);
    rd(4'h0, 8'h01, "R2 high byte alone must not push");
    wr(4'h3, 8'h05);
    rd(4'h0, 8'h00, "R2 low byte pushes");
    rd(4'h1, 8'h00, "R7 pending pattern not readable");
    run(10);
    rd(4'h1, 8'h13, "R7 data reads driven pattern, upper bits 0");
    rd(4'h0, 8'h01, "R4 entry popped on issue");

    // R8: two channels in the same cycle
    sched(1, 8'h03, 4);
    sched(2, 8'h0C, 4);
    run(6);
    chk("R8 pat_o is OR of channels", {3'b0, pat}, 8'h1F);

    // R3: depth 4, fifth push dropped
    for (int i = 0; i < 5; i++) begin
      sched(1, 8'(1 << i), 100 + i);
      if (i == 3) rd(4'h4, 8'h02, "R3 full flag at 4 entries");
    end
    rd(4'h4, 8'h02, "R3 full stays after dropped push");
    run(110);
    rd(4'h5, 8'h08, "R3 fifth entry was dropped");
    rd(4'h4, 8'h01, "R3 queue drained");

    // R6: clear
    sched(2, 8'h01, 5);
    sched(2, 8'h02, 6);
    wr(4'h8, 8'h00);
    rd(4'h8, 8'h00, "R6 writing 0 to clear has no effect");
    wr(4'h8, 8'h04);
    rd(4'h8, 8'h01, "R6 clear empties, bit2 reads 0");
    run(10);
    rd(4'h9, 8'h0C, "R6 cleared entries never issue");

    // R5: stalled counter
    sched(0, 8'h07, 3);
    repeat (20) @(negedge clk);
    rd(4'h1, 8'h13, "R5 stalled counter does not reach time");
    run(5);
    rd(4'h1, 8'h07, "R5 counter resumes and entry issues");

    // R10: in-order issue
    sched(0, 8'h0A, 20);
    sched(0, 8'h15, 10);
    run(15);
    rd(4'h1, 8'h07, "R10 younger entry blocked behind head");
    run(10);
    rd(4'h1, 8'h0A, "R10 head issues at its time");
    rd(4'h0, 8'h00, "R10 blocked entry still queued");
    wr(4'h0, 8'h04);
    rd(4'h0, 8'h01, "R6 clear removes blocked entry");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      body();
      begin repeat (100000) @(posedge clk); timeout = 1'b1; end
    join_any
    disable fork;
    if (timeout) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule